// File: doc/BRIEF.md
# Input Mode Channel Sequencer

This block keeps the 8-bit converter control byte and turns it into the selection that the analog input multiplexer needs. The stored byte picks one of four input configurations: four single-ended inputs, three differential pairs, a mixed set, or two differential pairs. It also picks a channel number within that configuration. The block produces a positive input select, a negative input select and a flag that marks a differential channel.

A write strobe loads a new control byte. If the requested channel does not exist in the chosen configuration, the block clamps it to the highest channel that does exist. A pulse on `conv_start` captures the current selection into held outputs, and the conversion uses those outputs. A pulse on `conv_done` ends the conversion. When auto-advance is on, the same pulse moves the channel forward and wraps it to 0 after the highest channel. The block also drives the analog-output enable and keeps the oscillator running while that enable is set or a conversion is in progress.

Top module: `chan_seq`

## Requirements
- R1: After reset, `ctrl_q` is 0x00, `aout_en`, `osc_run` and `conv_diff` are 0, and `conv_pos`/`conv_neg` are 0.
- R2: A write stores the byte with bits 7 and 3 forced to 0. `ctrl_q` shows it as {0, out-enable(6), mode(5:4), 0, auto(2), channel(1:0)} on the cycle after the strobe.
- R3: Decode of (mode, channel) into (pos, neg, diff). Mode 00: (ch, 0, 0). Mode 01: (ch, 3, 1). Mode 10: channels 0 and 1 give (ch, 0, 0), and channel 2 gives (2, 3, 1). Mode 11: channel 0 gives (0, 1, 1), and channel 1 gives (2, 3, 1).
- R4: A written channel above the mode's highest channel is stored as that highest channel. The highest channel is 3 for mode 00, 2 for modes 01 and 10, and 1 for mode 11.
- R5: When auto (bit 2) is set, each `conv_done` pulse moves the channel forward by one, and the highest channel wraps to 0.
- R6: When auto is clear, `conv_done` leaves the channel unchanged.
- R7: `conv_pos`, `conv_neg` and `conv_diff` load the decode of the stored selection on a `conv_start` pulse and hold at all other times.
- R8: `aout_en` equals stored bit 6.
- R9: `osc_run` is 1 while `aout_en` is 1 or while a conversion runs (from `conv_start` until `conv_done`), and 0 otherwise.
- R10: When a write and `conv_done` arrive in the same cycle, the written channel is kept and no advance is applied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wr | input | 1 | Control byte write strobe |
| cfg_data | input | 8 | Control byte to write |
| conv_start | input | 1 | Conversion start pulse, captures selection |
| conv_done | input | 1 | Conversion complete pulse |
| ctrl_q | output | 8 | Stored control byte with clamped channel |
| aout_en | output | 1 | Analog output enable |
| osc_run | output | 1 | Oscillator run request |
| conv_pos | output | 2 | Captured positive input select |
| conv_neg | output | 2 | Captured negative input select |
| conv_diff | output | 1 | Captured channel is differential |

## Verification
The assertions run on every cycle. They check that the stored channel never goes past the mode's limit, that the channel wraps from the highest value to 0, and that it holds when auto is off. They also check that the captured selection stays fixed between start pulses and that an enabled output always keeps the oscillator running. Some behaviours can only be shown by the bench scenarios: the full decode table over all 256 control bytes, clamping of every illegal channel, complete advance sequences across several conversions, and the priority of a write over a finishing conversion in the same cycle.

// File: rtl/chan_seq.sv
module chan_seq (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cfg_wr,
  input  logic [7:0] cfg_data,
  input  logic       conv_start,
  input  logic       conv_done,
  output logic [7:0] ctrl_q,
  output logic       aout_en,
  output logic       osc_run,
  output logic [1:0] conv_pos,
  output logic [1:0] conv_neg,
  output logic       conv_diff
);

  logic       aoe_q, ainc_q, busy_q;
  logic [1:0] mode_q, chan_q;
  logic [1:0] cpos_q, cneg_q;
  logic       cdiff_q;

  function automatic logic [1:0] top_chan(input logic [1:0] m);
    case (m)
      2'b00:   return 2'd3;
      2'b11:   return 2'd1;
      default: return 2'd2;
    endcase
  endfunction

  logic [1:0] wr_top, wr_chan, cur_top, adv_chan;
  assign wr_top   = top_chan(cfg_data[5:4]);
  assign wr_chan  = (cfg_data[1:0] > wr_top) ? wr_top : cfg_data[1:0];
  assign cur_top  = top_chan(mode_q);
  assign adv_chan = (chan_q == cur_top) ? 2'd0 : chan_q + 2'd1;

  logic [1:0] dec_pos, dec_neg;
  logic       dec_diff;
  always_comb begin
    dec_pos  = chan_q;
    dec_neg  = 2'd0;
    dec_diff = 1'b0;
    case (mode_q)
      2'b01: begin
        dec_neg  = 2'd3;
        dec_diff = 1'b1;
      end
      2'b10: if (chan_q == 2'd2) begin
        dec_neg  = 2'd3;
        dec_diff = 1'b1;
      end
      2'b11: begin
        dec_pos  = {chan_q[0], 1'b0};
        dec_neg  = {chan_q[0], 1'b1};
        dec_diff = 1'b1;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      aoe_q  <= 1'b0;
      ainc_q <= 1'b0;
      mode_q <= 2'b00;
      chan_q <= 2'd0;
    end else if (cfg_wr) begin
      aoe_q  <= cfg_data[6];
      ainc_q <= cfg_data[2];
      mode_q <= cfg_data[5:4];
      chan_q <= wr_chan;
    end else if (conv_done && ainc_q) begin
      chan_q <= adv_chan;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q  <= 1'b0;
      cpos_q  <= 2'd0;
      cneg_q  <= 2'd0;
      cdiff_q <= 1'b0;
    end else begin
      if (conv_start) begin
        busy_q  <= 1'b1;
        cpos_q  <= dec_pos;
        cneg_q  <= dec_neg;
        cdiff_q <= dec_diff;
      end else if (conv_done) begin
        busy_q <= 1'b0;
      end
    end
  end

  assign ctrl_q    = {1'b0, aoe_q, mode_q, 1'b0, ainc_q, chan_q};
  assign aout_en   = aoe_q;
  assign osc_run   = aoe_q | busy_q;
  assign conv_pos  = cpos_q;
  assign conv_neg  = cneg_q;
  assign conv_diff = cdiff_q;

endmodule

module chan_seq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       cfg_wr,
  input logic       conv_start,
  input logic       conv_done,
  input logic [7:0] ctrl_q,
  input logic       aout_en,
  input logic       osc_run,
  input logic [1:0] conv_pos,
  input logic [1:0] conv_neg,
  input logic       conv_diff
);
  logic [1:0] lim;
  always_comb
    case (ctrl_q[5:4])
      2'b00:   lim = 2'd3;
      2'b11:   lim = 2'd1;
      default: lim = 2'd2;
    endcase

  AST_CHAN_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_q[1:0] <= lim); // R4
  AST_WRAP_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (conv_done && !cfg_wr && ctrl_q[2] && ctrl_q[1:0] == lim) |=> ctrl_q[1:0] == 2'd0); // R5
  AST_HOLD_NO_AUTO: assert property (@(posedge clk) disable iff (!rst_n)
    (conv_done && !cfg_wr && !ctrl_q[2]) |=> $stable(ctrl_q[1:0])); // R6
  AST_SEL_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    !conv_start |=> ($stable(conv_pos) && $stable(conv_neg) && $stable(conv_diff))); // R7
  AST_OSC_WITH_OUT: assert property (@(posedge clk) disable iff (!rst_n)
    aout_en |-> osc_run); // R9
  AST_OSC_IN_CONV: assert property (@(posedge clk) disable iff (!rst_n)
    conv_start |=> osc_run); // R9
endmodule

bind chan_seq chan_seq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .conv_start(conv_start),
  .conv_done(conv_done), .ctrl_q(ctrl_q), .aout_en(aout_en), .osc_run(osc_run),
  .conv_pos(conv_pos), .conv_neg(conv_neg), .conv_diff(conv_diff)
);

// File: tb/tb_chan_seq.sv
module tb_chan_seq;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cfg_wr = 1'b0;
  logic [7:0] cfg_data = 8'h00;
  logic       conv_start = 1'b0;
  logic       conv_done = 1'b0;
  logic [7:0] ctrl_q;
  logic       aout_en, osc_run, conv_diff;
  logic [1:0] conv_pos, conv_neg;

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  chan_seq dut (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_data(cfg_data),
    .conv_start(conv_start), .conv_done(conv_done), .ctrl_q(ctrl_q),
    .aout_en(aout_en), .osc_run(osc_run), .conv_pos(conv_pos),
    .conv_neg(conv_neg), .conv_diff(conv_diff)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int lim_of(input int m);
    return (m == 0) ? 3 : (m == 3) ? 1 : 2;
  endfunction

  function automatic int exp_pos(input int m, input int c);
    return (m == 3) ? c * 2 : c;
  endfunction
  function automatic int exp_neg(input int m, input int c);
    if (m == 1 || (m == 2 && c == 2)) return 3;
    if (m == 3) return c * 2 + 1;
    return 0;
  endfunction
  function automatic int exp_diff(input int m, input int c);
    return (m == 1 || m == 3 || (m == 2 && c == 2)) ? 1 : 0;
  endfunction

  task automatic pulse_wr(input logic [7:0] b, input logic done);
    @(negedge clk);
    cfg_wr = 1'b1; cfg_data = b; conv_done = done;
    @(negedge clk);
    cfg_wr = 1'b0; conv_done = 1'b0;
  endtask

  task automatic pulse_start();
    @(negedge clk); conv_start = 1'b1;
    @(negedge clk); conv_start = 1'b0;
  endtask

  task automatic pulse_done();
    @(negedge clk); conv_done = 1'b1;
    @(negedge clk); conv_done = 1'b0;
  endtask

  initial begin
    #400000;
    if (!finished) begin
      checks++; failures++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 ctrl", ctrl_q, 0);
    chk("R1 aout", aout_en, 0);
    chk("R1 osc", osc_run, 0);
    chk("R1 pos", conv_pos, 0);
    chk("R1 neg", conv_neg, 0);
    chk("R1 diff", conv_diff, 0);

    for (int b = 0; b < 256; b++) begin
      int m, c, ai, ao, lim;
      m = (b >> 4) & 3; c = b & 3; ai = (b >> 2) & 1; ao = (b >> 6) & 1;
      lim = lim_of(m);
      if (c > lim) c = lim;
      pulse_wr(b[7:0], 1'b0);
      chk("R2 ctrl", ctrl_q, (ao << 6) | (m << 4) | (ai << 2) | c);
      chk("R4 clamp", ctrl_q[1:0], c);
      chk("R8 aout", aout_en, ao);
      chk("R9 osc idle", osc_run, ao);
      for (int k = 0; k < 5; k++) begin
        pulse_start();
        chk("R3 pos", conv_pos, exp_pos(m, c));
        chk("R3 neg", conv_neg, exp_neg(m, c));
        chk("R3 diff", conv_diff, exp_diff(m, c));
        chk("R9 osc busy", osc_run, 1);
        pulse_done();
        chk("R9 osc after", osc_run, ao);
        chk("R7 held pos", conv_pos, exp_pos(m, c));
        if (ai) c = (c == lim) ? 0 : c + 1;
        if (ai) chk("R5 advance", ctrl_q[1:0], c);
        else    chk("R6 hold", ctrl_q[1:0], c);
      end
    end

    pulse_wr(8'h07, 1'b0);
    pulse_wr(8'h05, 1'b1);
    chk("R10 write wins", ctrl_q[1:0], 1);
    pulse_wr(8'h36, 1'b1);
    chk("R10 write wins clamp", ctrl_q[1:0], 1);
    chk("R10 mode", ctrl_q[5:4], 3);

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule